// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block decides, for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back), when an instruction may move forward, which copy of each ALU operand the execute stage should use, and when a fetched instruction must be thrown away. It watches the two source registers of the instruction in decode. It also watches the destination register, write enable and load flag of the instructions one and two stages ahead. From these it drives the operand bypass selects, a hold for the program counter and the fetch/decode register, a bubble into the decode/execute register, and a squash of the fetch/decode register.

The bypass selects are worked out in decode and registered, so they change at the same clock edge that moves the consumer into execute. An ALU result is bypassed without any wait. A value loaded by the instruction directly ahead costs one stall cycle, and after that it is bypassed from the write-back side. The register file writes early in a cycle and reads late, so a producer three instructions back needs no bypass. Branches are resolved in decode and fetch assumes the fall-through path. A taken branch squashes the one instruction already fetched.

Top module: `pipe_hazard_unit`

## Requirements
- R1: The operand selects `fwd_a`/`fwd_b` use the encoding 2'b00 = register file, 2'b10 = bypass from the EX/MEM register, 2'b01 = bypass from the MEM/WB register. The value 2'b11 never appears.
- R2: The instruction directly ahead is a register-writing non-load with a nonzero destination equal to a decode source. For the cycle after the edge that moves the consumer into execute, that operand's select is 2'b10 and no stall is raised.
- R3: The instruction two ahead writes a nonzero destination equal to a decode source, and the instruction directly ahead does not. That operand's select becomes 2'b10's neighbour 2'b01 at the next edge.
- R4: When both producers match the same source, the nearer one wins (2'b10).
- R5: A producer three instructions back causes no bypass (select 2'b00) and no stall.
- R6: A destination of register 0, or a producer with its write enable low, triggers neither a bypass nor a stall.
- R7: The instruction directly ahead is a load with a nonzero destination equal to either decode source. In that same cycle `pc_hold` and `idex_bubble` are both 1, and the selects registered at the next edge are 2'b00 (for the bubble).
- R8: One cycle after a load-use stall, the same consumer is bypassed from MEM/WB (2'b01), and only one stall cycle occurs.
- R9: A load directly ahead whose destination matches neither decode source raises no stall.
- R10: `ifid_flush` is 1 for a taken branch in decode. During a stall it is 0, because the branch waits in decode.
- R11: While `rst_n` is low at a clock edge, both selects are cleared to 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs_a | input | REG_ADDR_W | First source register of the decode instruction |
| id_rs_b | input | REG_ADDR_W | Second source register of the decode instruction |
| ex_rd | input | REG_ADDR_W | Destination of the instruction in ID/EX |
| ex_we | input | 1 | Register write enable of the instruction in ID/EX |
| ex_is_load | input | 1 | Instruction in ID/EX is a load |
| mem_rd | input | REG_ADDR_W | Destination of the instruction in EX/MEM |
| mem_we | input | 1 | Register write enable of the instruction in EX/MEM |
| branch_taken | input | 1 | Branch in decode resolved as taken |
| fwd_a | output | 2 | Operand A source select for execute |
| fwd_b | output | 2 | Operand B source select for execute |
| pc_hold | output | 1 | Hold PC and the IF/ID register |
| idex_bubble | output | 1 | Load a bubble with write enables cleared into ID/EX |
| ifid_flush | output | 1 | Squash the instruction in IF/ID |

## Verification
The bench builds the block with the default five-bit register numbers, so every register name used by the scenarios, register 0 included, can be reached directly. It replays short instruction streams by placing each instruction in the decode, ID/EX and EX/MEM inputs cycle by cycle: an ALU result consumed by three followers, a load consumed at once, and a load that is not consumed. These streams exercise both bypass distances, the three-apart case that needs no bypass, priority between the two producers, the single stall cycle, and how a taken branch interacts with that stall.

// File: rtl/hz_pkg.sv
// Shared types for the hazard controller.
package hz_pkg;
    // Operand source for the execute stage; codes are seen by the datapath mux.
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
// Compares one decode-stage source register against the two producers ahead
// of it and picks the bypass source it will need once it reaches execute.
// Assumes register 0 is hard-wired to zero and never bypassed.
module hz_src_match #(
    parameter int REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] src,
    input  logic [REG_ADDR_W-1:0] near_rd,
    input  logic                  near_we,
    input  logic [REG_ADDR_W-1:0] far_rd,
    input  logic                  far_we,
    output logic                  near_hit,
    output hz_pkg::fwd_sel_e      sel
);
    localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

    logic far_hit;

    // Match against each producer, ignoring register 0 and non-writers.
    always_comb begin
        near_hit = near_we && (near_rd != ZERO_REG) && (near_rd == src);
        far_hit  = far_we  && (far_rd  != ZERO_REG) && (far_rd  == src);
    end

    // Nearer producer holds the newer value, so it takes priority.
    always_comb begin
        if (near_hit)
            sel = hz_pkg::FWD_MEM;
        else if (far_hit)
            sel = hz_pkg::FWD_WB;
        else
            sel = hz_pkg::FWD_RF;
    end
endmodule

// File: rtl/hz_load_interlock.sv
// Raises a one-cycle stall when the instruction directly ahead is a load whose
// destination a decode source needs; bypass cannot deliver that value in time.
module hz_load_interlock #(
    parameter int NUM_OPS = 2
) (
    input  logic               near_is_load,
    input  logic [NUM_OPS-1:0] near_hit,
    output logic               stall
);
    // Any source matching a pending load forces the interlock.
    always_comb begin
        stall = near_is_load && (|near_hit);
    end
endmodule

// File: rtl/hz_fwd_regs.sv
// Holds the bypass selects for the instruction in execute. A stall turns the
// ID/EX entry into a bubble, so its selects are cleared instead of loaded.
module hz_fwd_regs #(
    parameter int NUM_OPS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bubble,
    input  hz_pkg::fwd_sel_e sel_d [NUM_OPS],
    output hz_pkg::fwd_sel_e sel_q [NUM_OPS]
);
    genvar g;
    generate
        for (g = 0; g < NUM_OPS; g++) begin : g_op
            // Advance the select with the instruction, or clear it for a bubble.
            always_ff @(posedge clk) begin
                if (!rst_n || bubble)
                    sel_q[g] <= hz_pkg::FWD_RF;
                else
                    sel_q[g] <= sel_d[g];
            end
        end
    endgenerate
endmodule

// File: rtl/pipe_hazard_unit.sv
// Hazard controller for a five-stage in-order pipeline. Bypass selects are
// computed in decode and registered into execute; a load consumed directly
// behind it costs one stall; a taken branch resolved in decode squashes the
// fall-through fetch. Assumes a register file that writes before it reads.
module pipe_hazard_unit #(
    parameter int REG_ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] id_rs_a,
    input  logic [REG_ADDR_W-1:0] id_rs_b,
    input  logic [REG_ADDR_W-1:0] ex_rd,
    input  logic                  ex_we,
    input  logic                  ex_is_load,
    input  logic [REG_ADDR_W-1:0] mem_rd,
    input  logic                  mem_we,
    input  logic                  branch_taken,
    output logic [1:0]            fwd_a,
    output logic [1:0]            fwd_b,
    output logic                  pc_hold,
    output logic                  idex_bubble,
    output logic                  ifid_flush
);
    localparam int NUM_OPS = 2;

    logic [REG_ADDR_W-1:0] src      [NUM_OPS];
    hz_pkg::fwd_sel_e      sel_d    [NUM_OPS];
    hz_pkg::fwd_sel_e      sel_q    [NUM_OPS];
    logic [NUM_OPS-1:0]    near_hit;
    logic                  stall;

    // Gather the decode sources into an indexable array.
    always_comb begin
        src[0] = id_rs_a;
        src[1] = id_rs_b;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_OPS; g++) begin : g_src
            hz_src_match #(.REG_ADDR_W(REG_ADDR_W)) u_match (
                .src      (src[g]),
                .near_rd  (ex_rd),
                .near_we  (ex_we),
                .far_rd   (mem_rd),
                .far_we   (mem_we),
                .near_hit (near_hit[g]),
                .sel      (sel_d[g])
            );
        end
    endgenerate

    hz_load_interlock #(.NUM_OPS(NUM_OPS)) u_interlock (
        .near_is_load (ex_is_load),
        .near_hit     (near_hit),
        .stall        (stall)
    );

    hz_fwd_regs #(.NUM_OPS(NUM_OPS)) u_fwd (
        .clk    (clk),
        .rst_n  (rst_n),
        .bubble (stall),
        .sel_d  (sel_d),
        .sel_q  (sel_q)
    );

    // Drive the pipeline controls; a stalled branch waits rather than squashes.
    always_comb begin
        fwd_a       = sel_q[0];
        fwd_b       = sel_q[1];
        pc_hold     = stall;
        idex_bubble = stall;
        ifid_flush  = branch_taken && !stall;
    end
endmodule

// File: rtl/pipe_hazard_unit_chk.sv
// Property checks for the hazard controller, attached by bind.
module pipe_hazard_unit_chk #(
    parameter int REG_ADDR_W = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_ADDR_W-1:0] id_rs_a,
    input logic [REG_ADDR_W-1:0] ex_rd,
    input logic                  ex_we,
    input logic                  ex_is_load,
    input logic [1:0]            fwd_a,
    input logic [1:0]            fwd_b,
    input logic                  pc_hold,
    input logic                  ifid_flush
);
    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a != 2'b11) && (fwd_b != 2'b11));

    // R2
    near_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_we && !ex_is_load && ex_rd != '0 && ex_rd == id_rs_a)
        |=> (fwd_a == 2'b10));

    // R6
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0 || !ex_we) |-> !pc_hold);

    // R7
    bubble_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> (fwd_a == 2'b00 && fwd_b == 2'b00));

    // R10
    no_flush_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |-> !ifid_flush);
endmodule

bind pipe_hazard_unit pipe_hazard_unit_chk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_rs_a    (id_rs_a),
    .ex_rd      (ex_rd),
    .ex_we      (ex_we),
    .ex_is_load (ex_is_load),
    .fwd_a      (fwd_a),
    .fwd_b      (fwd_b),
    .pc_hold    (pc_hold),
    .ifid_flush (ifid_flush)
);

// File: tb/test_pipe_hazard_unit.sv
// Directed bench: each task replays one instruction stream and checks results.
module test_pipe_hazard_unit;
    localparam int CLK_PERIOD = 10;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] id_rs_a = '0, id_rs_b = '0, ex_rd = '0, mem_rd = '0;
    logic          ex_we = 1'b0, ex_is_load = 1'b0, mem_we = 1'b0, branch_taken = 1'b0;
    logic [1:0]    fwd_a, fwd_b;
    logic          pc_hold, idex_bubble, ifid_flush;

    int checks = 0;
    int errors = 0;
    int stalls = 0;
    bit done = 1'b0;

    // Values captured during the last call of step().
    logic       c_hold, c_bubble, c_flush;
    logic [1:0] n_fa, n_fb;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_hazard_unit #(.REG_ADDR_W(RW)) i_pipe_hazard_unit (
        .clk(clk), .rst_n(rst_n), .id_rs_a(id_rs_a), .id_rs_b(id_rs_b),
        .ex_rd(ex_rd), .ex_we(ex_we), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_we(mem_we), .branch_taken(branch_taken),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold),
        .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply one cycle of stage contents (called just after a falling edge);
    // capture controls mid-cycle and the selects just after the rising edge.
    task automatic step(input logic [RW-1:0] ra, input logic [RW-1:0] rb,
                        input logic [RW-1:0] erd, input logic ewe, input logic eld,
                        input logic [RW-1:0] mrd, input logic mwe, input logic br);
        id_rs_a = ra; id_rs_b = rb; ex_rd = erd; ex_we = ewe; ex_is_load = eld;
        mem_rd = mrd; mem_we = mwe; branch_taken = br;
        #1;
        c_hold = pc_hold; c_bubble = idex_bubble; c_flush = ifid_flush;
        if (pc_hold) stalls++;
        @(posedge clk); #1;
        n_fa = fwd_a; n_fb = fwd_b;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(5'd1, 5'd1, 5'd1, 1'b1, 1'b0, 5'd1, 1'b1, 1'b0);
        chk("R11 fwd_a in reset", n_fa, 2'b00);
        chk("R11 fwd_b in reset", n_fb, 2'b00);
        rst_n = 1'b1;
        step(5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0);
        chk("R1 idle select", n_fa, 2'b00);
        chk("R1 idle hold", {1'b0, c_hold}, 2'b00);
    endtask

    // add r1 ; sub r4,r1,r3 ; and r6,r1,r7 ; or r8,r1,r9
    task automatic t_alu_chain();
        stalls = 0;
        step(5'd1, 5'd3, 5'd1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0);
        chk("R2 sub gets EX/MEM", n_fa, 2'b10);
        chk("R2 sub other operand", n_fb, 2'b00);
        step(5'd1, 5'd7, 5'd4, 1'b1, 1'b0, 5'd1, 1'b1, 1'b0);
        chk("R3 and gets MEM/WB", n_fa, 2'b01);
        step(5'd1, 5'd9, 5'd6, 1'b1, 1'b0, 5'd4, 1'b1, 1'b0);
        chk("R5 or uses register file", n_fa, 2'b00);
        chk("R2 no stall in ALU chain", stalls[1:0], 2'd0);
    endtask

    task automatic t_priority();
        step(5'd5, 5'd5, 5'd5, 1'b1, 1'b0, 5'd5, 1'b1, 1'b0);
        chk("R4 nearer wins A", n_fa, 2'b10);
        chk("R4 nearer wins B", n_fb, 2'b10);
    endtask

    // lw r1 ; sub r4,r1,r3
    task automatic t_load_use();
        stalls = 0;
        step(5'd1, 5'd3, 5'd1, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0);
        chk("R7 hold raised", {1'b0, c_hold}, 2'b01);
        chk("R7 bubble raised", {1'b0, c_bubble}, 2'b01);
        chk("R7 bubble selects", n_fa, 2'b00);
        step(5'd1, 5'd3, 5'd0, 1'b0, 1'b0, 5'd1, 1'b1, 1'b0);
        chk("R8 load value from MEM/WB", n_fa, 2'b01);
        chk("R8 single stall cycle", stalls[1:0], 2'd1);
        // load destination on operand B also interlocks
        step(5'd2, 5'd8, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0);
        chk("R7 operand B interlock", {1'b0, c_hold}, 2'b01);
    endtask

    task automatic t_load_unused();
        step(5'd2, 5'd3, 5'd1, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0);
        chk("R9 unused load no stall", {1'b0, c_hold}, 2'b00);
        chk("R9 selects", n_fa, 2'b00);
    endtask

    task automatic t_zero_and_we();
        step(5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0);
        chk("R6 r0 load no stall", {1'b0, c_hold}, 2'b00);
        chk("R6 r0 no bypass", n_fa, 2'b00);
        step(5'd4, 5'd4, 5'd4, 1'b0, 1'b1, 5'd4, 1'b0, 1'b0);
        chk("R6 we low no stall", {1'b0, c_hold}, 2'b00);
        chk("R6 we low no bypass", n_fb, 2'b00);
    endtask

    task automatic t_branch();
        step(5'd2, 5'd3, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1);
        chk("R10 taken flushes", {1'b0, c_flush}, 2'b01);
        chk("R10 taken no hold", {1'b0, c_hold}, 2'b00);
        step(5'd1, 5'd3, 5'd1, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1);
        chk("R10 no flush while stalled", {1'b0, c_flush}, 2'b00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_alu_chain();
        t_priority();
        t_load_use();
        t_load_unused();
        t_zero_and_we();
        t_branch();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule